// File: doc/BRIEF.md
# Framed PRBS7 Test Pattern Generator

This block produces a continuous serial self-test pattern at one bit per clock. The pattern is built as repeating frames. Each frame starts with a header made of a run of A1 bytes followed by a run of A2 bytes. A pseudorandom payload of PRBS7 bits fills the rest of the frame, and the frame length is fixed.

The stream is fanned out to several channel outputs. Channel 0 carries the stream, and each higher channel carries the same stream one clock later than the channel below it. A start-of-frame marker flags the cycle in which channel 0 carries the first header bit.

An enable input pauses the generator. The active-low reset, which is shared with the frame detector downstream, restarts the pattern at the start of the header. It asserts asynchronously and is released synchronously inside the block.

Top module: `framed_prbs_tx`

## Requirements
- R1: While reset is low, every channel output and the frame marker are 0. After reset is released, the first enabled clock edge puts frame bit 0 on channel 0.
- R2: Each frame begins with A1_COUNT bytes of 0xF6 followed by A2_COUNT bytes of 0x28. Each byte is sent most significant bit first on channel 0.
- R3: The header is followed by PAYLOAD_BYTES*8 payload bits, produced by a 7-bit state s that is seeded to 0x7F at reset. Each payload bit is s[6], and s then becomes {s[5:0], s[6]^s[5]} (polynomial x^7+x^6+1). The first payload bit after reset is therefore 1.
- R4: The payload state is never reseeded at a frame boundary. The payload of each frame continues the sequence where the previous frame's payload ended.
- R5: Channel k carries the bit that channel 0 carried k enabled cycles earlier. It outputs 0 until that many bits have been produced.
- R6: The frame length is (A1_COUNT+A2_COUNT+PAYLOAD_BYTES)*8 bits and frames repeat back to back. The marker sof is 1 exactly in the cycles where channel 0 carries frame bit 0.
- R7: A clock edge with enable low drives every channel output and sof to 0 and leaves the pattern position unchanged. The next enabled edge outputs the next bit of the stream.
- R8: Asserting reset in the middle of a frame restarts the stream at frame bit 0 with the payload state reseeded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| enable | input | 1 | Advances the pattern when high |
| ch_out | output | NUM_CH | Channel bits, channel k skewed by k clocks |
| sof | output | 1 | Frame-start marker aligned with channel 0 |

## Verification
Several rules are checked on every cycle: the channel-to-channel delay, zero outputs after a disabled edge, position and payload-state freezing while disabled, the position staying in range and wrapping, and a non-zero payload state. The exact header bytes, the payload sequence values, and its continuation across frame boundaries can only be shown by the bench comparing the stream against a model. The same holds for the restart after a mid-frame reset and for resumption after pauses.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  typedef enum logic [1:0] {
    SEG_A1  = 2'd0,
    SEG_A2  = 2'd1,
    SEG_PAY = 2'd2
  } seg_e;

  localparam int PRBS_W = 7;
endpackage

// File: rtl/ptg_frame_seq.sv
module ptg_frame_seq
  import ptg_pkg::*;
#(
  parameter int          A1_COUNT      = 12,
  parameter int          A2_COUNT      = 12,
  parameter int          PAYLOAD_BYTES = 9696,
  parameter logic [7:0]  A1_BYTE       = 8'hF6,
  parameter logic [7:0]  A2_BYTE       = 8'h28,
  localparam int         FRAME_BITS    = (A1_COUNT + A2_COUNT + PAYLOAD_BYTES) * 8,
  localparam int         POS_W         = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output seg_e             seg_o,
  output logic             hdr_bit_o,
  output logic             at_start_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int A1_END = A1_COUNT * 8;
  localparam int A2_END = (A1_COUNT + A2_COUNT) * 8;

  logic [POS_W-1:0] pos_q, pos_d;
  logic [2:0]       bit_sel;

  always_comb begin
    pos_d = pos_q;
    if (adv) begin
      if (pos_q == POS_W'(FRAME_BITS - 1)) pos_d = '0;
      else                                  pos_d = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  always_comb begin
    if (pos_q < POS_W'(A1_END))      seg_o = SEG_A1;
    else if (pos_q < POS_W'(A2_END)) seg_o = SEG_A2;
    else                             seg_o = SEG_PAY;
  end

  assign bit_sel    = ~pos_q[2:0];
  assign hdr_bit_o  = (seg_o == SEG_A1) ? A1_BYTE[bit_sel] : A2_BYTE[bit_sel];
  assign at_start_o = (pos_q == '0);
  assign pos_o      = pos_q;
endmodule

// File: rtl/ptg_prbs7.sv
module ptg_prbs7
  import ptg_pkg::*;
#(
  parameter logic [PRBS_W-1:0] SEED = 7'h7F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic              bit_o,
  output logic [PRBS_W-1:0] state_o
);
  localparam int TAP_HI = PRBS_W - 1;
  localparam int TAP_LO = PRBS_W - 2;

  logic [PRBS_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (step) st_d = {st_q[PRBS_W-2:0], st_q[TAP_HI] ^ st_q[TAP_LO]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign bit_o   = st_q[TAP_HI];
  assign state_o = st_q;
endmodule

// File: rtl/ptg_skew_line.sv
module ptg_skew_line #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              din,
  output logic [NUM_CH-1:0] taps_o
);
  logic [NUM_CH-1:0] tap_q, tap_d;

  genvar k;
  generate
    for (k = 0; k < NUM_CH; k++) begin : g_tap
      if (k == 0) begin : g_head
        always_comb tap_d[k] = adv ? din : tap_q[k];
      end else begin : g_body
        always_comb tap_d[k] = adv ? tap_q[k-1] : tap_q[k];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_d;
  end

  assign taps_o = tap_q;
endmodule

// File: rtl/framed_prbs_tx.sv
module framed_prbs_tx
  import ptg_pkg::*;
#(
  parameter int          NUM_CH        = 4,
  parameter int          A1_COUNT      = 12,
  parameter int          A2_COUNT      = 12,
  parameter int          PAYLOAD_BYTES = 9696,
  parameter logic [7:0]  A1_BYTE       = 8'hF6,
  parameter logic [7:0]  A2_BYTE       = 8'h28,
  parameter logic [6:0]  PRBS_SEED     = 7'h7F,
  localparam int         FRAME_BITS    = (A1_COUNT + A2_COUNT + PAYLOAD_BYTES) * 8,
  localparam int         POS_W         = $clog2(FRAME_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  output logic [NUM_CH-1:0] ch_out,
  output logic              sof
);
  logic              rst_meta_q, rst_core_n;
  seg_e              seg;
  logic              hdr_bit, at_start, prbs_bit, stream_bit;
  logic [POS_W-1:0]  seq_pos;
  logic [PRBS_W-1:0] prbs_state;
  logic [NUM_CH-1:0] taps;
  logic              out_en_q, out_en_d;
  logic              sof_q, sof_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  ptg_frame_seq #(
    .A1_COUNT(A1_COUNT), .A2_COUNT(A2_COUNT), .PAYLOAD_BYTES(PAYLOAD_BYTES),
    .A1_BYTE(A1_BYTE), .A2_BYTE(A2_BYTE)
  ) seq_i (
    .clk(clk), .rst_n(rst_core_n), .adv(enable),
    .seg_o(seg), .hdr_bit_o(hdr_bit), .at_start_o(at_start), .pos_o(seq_pos)
  );

  ptg_prbs7 #(.SEED(PRBS_SEED)) prbs_i (
    .clk(clk), .rst_n(rst_core_n), .step(enable && (seg == SEG_PAY)),
    .bit_o(prbs_bit), .state_o(prbs_state)
  );

  assign stream_bit = (seg == SEG_PAY) ? prbs_bit : hdr_bit;

  ptg_skew_line #(.NUM_CH(NUM_CH)) skew_i (
    .clk(clk), .rst_n(rst_core_n), .adv(enable), .din(stream_bit), .taps_o(taps)
  );

  always_comb begin
    out_en_d = enable;
    sof_d    = enable ? at_start : sof_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_en_q <= 1'b0;
      sof_q    <= 1'b0;
    end else begin
      out_en_q <= out_en_d;
      sof_q    <= sof_d;
    end
  end

  assign ch_out = taps & {NUM_CH{out_en_q}};
  assign sof    = sof_q & out_en_q;
endmodule

// File: rtl/framed_prbs_tx_chk.sv
module framed_prbs_tx_chk #(
  parameter int   NUM_CH     = 4,
  parameter int   FRAME_BITS = 224,
  parameter int   POS_W      = 8,
  parameter logic A1_MSB     = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [NUM_CH-1:0] ch_out,
  input logic              sof,
  input logic [POS_W-1:0]  pos,
  input logic [6:0]        lfsr
);
  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ch_out == '0) && !sof);

  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(pos) && $stable(lfsr));

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pos < POS_W'(FRAME_BITS));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pos == POS_W'(FRAME_BITS - 1)) |=> (pos == '0));

  assert_sof_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> (ch_out[0] == A1_MSB));

  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 7'd0);

  genvar k;
  generate
    for (k = 1; k < NUM_CH; k++) begin : g_skew
      assert_skew_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(enable) && $past(enable, 2)) |-> (ch_out[k] == $past(ch_out[k-1])));
    end
  endgenerate
endmodule

bind framed_prbs_tx framed_prbs_tx_chk #(
  .NUM_CH(NUM_CH), .FRAME_BITS(FRAME_BITS), .POS_W(POS_W), .A1_MSB(A1_BYTE[7])
) chk_i (
  .clk(clk), .rst_n(rst_core_n), .enable(enable), .ch_out(ch_out), .sof(sof),
  .pos(seq_pos), .lfsr(prbs_state)
);

// File: tb/framed_prbs_tx_tb_top.sv
`timescale 1ns/1ps
module framed_prbs_tx_tb_top;
  localparam int NUM_CH   = 4;
  localparam int A1N      = 12;
  localparam int A2N      = 12;
  localparam int PAYN     = 4;
  localparam int FRAME    = (A1N + A2N + PAYN) * 8;
  localparam int STREAM_N = 1024;
  localparam int NVEC     = 7;
  localparam int VEC_EN [NVEC] = '{1, 0, 1, 0, 1, 0, 1};
  localparam int VEC_N  [NVEC] = '{40, 3, 300, 1, 250, 5, 200};

  logic clk = 1'b0;
  logic rst_n;
  logic enable;
  logic [NUM_CH-1:0] ch_out;
  logic sof;

  int checks = 0;
  int errors = 0;
  int t = 0;
  int cyc = 0;
  logic last_en = 1'b0;
  string ctx = "";
  logic stream [STREAM_N];

  always #4 clk = ~clk;

  framed_prbs_tx #(.NUM_CH(NUM_CH), .A1_COUNT(A1N), .A2_COUNT(A2N), .PAYLOAD_BYTES(PAYN)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ch_out(ch_out), .sof(sof)
  );

  task automatic build_stream();
    logic [6:0] s = 7'h7F;
    logic [7:0] a1 = 8'hF6;
    logic [7:0] a2 = 8'h28;
    for (int i = 0; i < STREAM_N; i++) begin
      int p = i % FRAME;
      if (p < A1N * 8) stream[i] = a1[7 - (p % 8)];
      else if (p < (A1N + A2N) * 8) stream[i] = a2[7 - (p % 8)];
      else begin
        stream[i] = s[6];
        s = {s[5:0], s[6] ^ s[5]};
      end
    end
  endtask

  task automatic check_outputs();
    for (int k = 0; k < NUM_CH; k++) begin
      int idx = t - 1 - k;
      logic e = (last_en && idx >= 0) ? stream[idx] : 1'b0;
      string tag;
      if (ctx != "") tag = ctx;
      else if (!last_en) tag = "R7";
      else if (k > 0) tag = "R5";
      else if (idx >= 0 && (idx % FRAME) < (A1N + A2N) * 8) tag = "R2";
      else if (idx >= FRAME) tag = "R4";
      else tag = "R3";
      checks++;
      if (ch_out[k] !== e) begin
        errors++;
        $display("FAIL %s ch%0d t=%0d actual=%b expected=%b", tag, k, t, ch_out[k], e);
      end
    end
    begin
      logic es = last_en && t >= 1 && ((t - 1) % FRAME) == 0;
      checks++;
      if (sof !== es) begin
        errors++;
        $display("FAIL %s sof t=%0d actual=%b expected=%b", (ctx != "") ? ctx : "R6", t, sof, es);
      end
    end
  endtask

  task automatic step(input logic e);
    enable = e;
    @(posedge clk);
    if (e) t++;
    last_en = e;
    @(negedge clk);
    check_outputs();
  endtask

  task automatic check_reset_zero(input string tag);
    checks++;
    if (ch_out !== '0 || sof !== 1'b0) begin
      errors++;
      $display("FAIL %s reset outputs actual=%b/%b expected=0/0", tag, ch_out, sof);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    build_stream();
    rst_n = 1'b0;
    enable = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_reset_zero("R1");
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0);
    ctx = "R1";
    step(1'b1);
    ctx = "";
    for (int v = 0; v < NVEC; v++)
      for (int n = 0; n < VEC_N[v]; n++) step(VEC_EN[v] != 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_zero("R8");
    @(negedge clk);
    check_reset_zero("R8");
    rst_n = 1'b1;
    t = 0;
    last_en = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0);
    ctx = "R8";
    for (int i = 0; i < FRAME + 10; i++) step(1'b1);
    ctx = "";
    step(1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule